// File: doc/BRIEF.md
# Split-Operand Booth Multiplier

This block multiplies two signed W-bit operands and returns the full 2W-bit signed product. Each operand is cut into a high half and a low half, which gives four half-width multiplications: high×high, the two mixed terms and low×low. Each of these runs on its own. For each of the four, the block compares how often the bits change in its two inputs and radix-4 Booth-encodes the quieter one. This choice raises the number of Booth digits that come out zero. The four results are weighted by 2^W, 2^(W/2), 2^(W/2) and 1 and added together.

Because the order decision is made per quarter rather than once for the whole word, a quarter can swap its inputs even when a whole-word comparison would leave them alone. A four-bit mask comes out with every product and reports which quarters swapped. Operands enter through a valid/ready port and leave through another. The pipeline has two stages. Stage one splits the operands, decides the order and recodes. Stage two builds the partial products and sums them. A result may wait in the output stage for as long as the consumer holds ready low. While it waits, the output does not change and the stage behind it keeps its contents.

Top module: `booth_part_mul`

## Requirements
- R1: When `out_valid` is high, `out_prod` equals the signed product of the `in_a` and `in_b` values that were accepted, as a 2W-bit two's-complement number. This holds for the most negative value on both inputs.
- R2: With `out_ready` held high, a pair accepted at one rising edge (`in_valid` and `in_ready` both high) shows up on the output with `out_valid` high after exactly two rising edges.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_prod` and `out_swap` stay unchanged. `in_ready` goes low only when both stages hold data and the output is stalled. No accepted pair is lost, and results leave in the order their pairs were accepted.
- R4: Every half is widened to W/2+1 bits: high halves are sign-extended and low halves are zero-extended. Its activity is the number of positions i from 0 to W/2 at which bit i differs from bit i-1, with bit -1 taken as 0. A quarter swaps when the activity of its half from `in_a` is strictly smaller than that of its half from `in_b`. A tie does not swap.
- R5: Bit k of `out_swap` belongs to one quarter. Bit 0 is low(a)×low(b), bit 1 is high(a)×low(b), bit 2 is low(a)×high(b) and bit 3 is high(a)×high(b). Each bit depends only on its own two halves, so a single quarter can swap on its own, as with a=0x0055, b=0x5500, which gives `out_swap`=4'b1000.
- R6: After reset `out_valid` is low and `in_ready` is high.
- R7: A zero on either input gives a product of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_a | input | W | Signed operand A |
| in_b | input | W | Signed operand B |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_prod | output | 2W | Signed product |
| out_swap | output | 4 | Per-quarter swap flags |

## Verification
The hardest condition to reach from the ports is a full pipeline. That means a result stalled at the output while a second pair sits in stage one, so that `in_ready` drops and both pairs must survive without being lost or reordered. The stimulus reaches it by driving `out_ready` from a random coin while new pairs are offered back to back, and it checks every result against a queue model. Quarters that swap on their own come from operands whose halves differ sharply in activity, such as alternating patterns placed next to all-zero or all-one halves.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } bdigit_t;

  function automatic bdigit_t booth_recode(input logic [2:0] t);
    bdigit_t d;
    d = '0;
    case (t)
      3'b001, 3'b010: d.one = 1'b1;
      3'b011:         d.two = 1'b1;
      3'b100:         begin d.two = 1'b1; d.neg = 1'b1; end
      3'b101, 3'b110: begin d.one = 1'b1; d.neg = 1'b1; end
      default:        d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/bit_activity.sv
module bit_activity #(
  parameter int N = 9,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  v,
  output logic [CW-1:0] cnt
);
  logic [N-1:0] edges;
  assign edges[0] = v[0];
  for (genvar i = 1; i < N; i++) begin : g_edge
    assign edges[i] = v[i] ^ v[i-1];
  end
  assign cnt = CW'($countones(edges));
endmodule

// File: rtl/lane_encode.sv
module lane_encode
  import booth_pkg::*;
#(
  parameter int H = 8,
  localparam int E  = H + 1,
  localparam int ND = (E + 1) / 2,
  localparam int EW = 2 * ND,
  localparam int CW = $clog2(E + 1)
) (
  input  logic [E-1:0] x,
  input  logic [E-1:0] y,
  output logic [E-1:0] mcand,
  output bdigit_t      digits [ND],
  output logic         swapped
);
  logic [CW-1:0] act_x, act_y;
  logic [E-1:0]  enc;
  logic [EW-1:0] enc_ext;

  bit_activity #(.N(E)) u_act_x (.v(x), .cnt(act_x));
  bit_activity #(.N(E)) u_act_y (.v(y), .cnt(act_y));

  assign swapped = act_x < act_y;
  assign enc     = swapped ? x : y;
  assign mcand   = swapped ? y : x;

  if (EW > E) begin : g_ext
    assign enc_ext = {{(EW-E){enc[E-1]}}, enc};
  end else begin : g_noext
    assign enc_ext = enc;
  end

  for (genvar i = 0; i < ND; i++) begin : g_dig
    if (i == 0) begin : g_first
      assign digits[i] = booth_recode({enc_ext[1], enc_ext[0], 1'b0});
    end else begin : g_rest
      assign digits[i] = booth_recode(enc_ext[2*i+1 : 2*i-1]);
    end
  end
endmodule

// File: rtl/lane_product.sv
module lane_product
  import booth_pkg::*;
#(
  parameter int H = 8,
  localparam int E  = H + 1,
  localparam int ND = (E + 1) / 2,
  localparam int PW = 2 * E
) (
  input  logic [E-1:0]  mcand,
  input  bdigit_t       digits [ND],
  output logic [PW-1:0] prod
);
  logic [PW-1:0] mx;
  assign mx = {{E{mcand[E-1]}}, mcand};

  always_comb begin
    logic [PW-1:0] acc;
    logic [PW-1:0] pp;
    acc = '0;
    for (int i = 0; i < ND; i++) begin
      if (digits[i].two)      pp = mx << 1;
      else if (digits[i].one) pp = mx;
      else                    pp = '0;
      if (digits[i].neg) pp = -pp;
      acc = acc + (pp << (2 * i));
    end
    prod = acc;
  end
endmodule

// File: rtl/booth_part_mul.sv
module booth_part_mul
  import booth_pkg::*;
#(
  parameter int W = 16,
  localparam int H  = W / 2,
  localparam int E  = H + 1,
  localparam int ND = (E + 1) / 2,
  localparam int PW = 2 * E
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*W-1:0] out_prod,
  output logic [3:0]     out_swap
);
  logic          s1_v;
  logic          s2_take;
  logic [E-1:0]  s1_mc [4];
  bdigit_t       s1_dg [4][ND];
  logic [3:0]    s1_sw;

  logic [E-1:0]  c_mc [4];
  bdigit_t       c_dg [4][ND];
  logic [3:0]    c_sw;
  logic [PW-1:0] c_pp [4];
  logic [2*W-1:0] c_wt [4];
  logic [2*W-1:0] c_sum;

  assign s2_take  = !out_valid || out_ready;
  assign in_ready = !s1_v || s2_take;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    localparam int SH = H * ((k & 1) + ((k >> 1) & 1));
    logic [E-1:0] xa, yb;
    if ((k & 1) != 0) begin : g_ahi
      assign xa = {in_a[W-1], in_a[W-1:H]};
    end else begin : g_alo
      assign xa = {1'b0, in_a[H-1:0]};
    end
    if ((k & 2) != 0) begin : g_bhi
      assign yb = {in_b[W-1], in_b[W-1:H]};
    end else begin : g_blo
      assign yb = {1'b0, in_b[H-1:0]};
    end

    lane_encode #(.H(H)) u_enc (
      .x(xa), .y(yb), .mcand(c_mc[k]), .digits(c_dg[k]), .swapped(c_sw[k])
    );

    lane_product #(.H(H)) u_pp (
      .mcand(s1_mc[k]), .digits(s1_dg[k]), .prod(c_pp[k])
    );

    assign c_wt[k] = {{(2*W-PW){c_pp[k][PW-1]}}, c_pp[k]} << SH;
  end

  assign c_sum = c_wt[0] + c_wt[1] + c_wt[2] + c_wt[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (in_ready) s1_v      <= in_valid;
      if (s2_take)  out_valid <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) begin
      s1_mc <= c_mc;
      s1_dg <= c_dg;
      s1_sw <= c_sw;
    end
    if (s2_take && s1_v) begin
      out_prod <= c_sum;
      out_swap <= s1_sw;
    end
  end
endmodule

// File: rtl/booth_part_mul_chk.sv
module booth_part_mul_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [W-1:0]   in_a,
  input logic [W-1:0]   in_b,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*W-1:0] out_prod,
  input logic [3:0]     out_swap
);
  logic [2*W-1:0] sa, sb, ref_p;
  logic           acc, adv;
  assign sa    = {{W{in_a[W-1]}}, in_a};
  assign sb    = {{W{in_b[W-1]}}, in_b};
  assign ref_p = sa * sb;
  assign acc   = in_valid && in_ready;
  assign adv   = !out_valid || out_ready;

  p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc, 2) && $past(adv)) |-> (out_prod == $past(ref_p, 2)));

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc, 2) && $past(adv)) |-> out_valid);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_prod) && $stable(out_swap)));

  p_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc && (in_a == '0 || in_b == '0), 2) && $past(adv)) |-> (out_prod == '0));
endmodule

bind booth_part_mul booth_part_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_prod(out_prod), .out_swap(out_swap)
);

// File: tb/booth_part_mul_tb_top.sv
module booth_part_mul_tb_top;
  localparam int W     = 16;
  localparam int H     = W / 2;
  localparam int CLK_P = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [W-1:0]   in_a = '0;
  logic [W-1:0]   in_b = '0;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic [2*W-1:0] out_prod;
  logic [3:0]     out_swap;

  int errs = 0, checks = 0, cyc = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  logic [2*W-1:0] qp[$];
  logic [3:0]     qm[$];
  int             qt[$];
  bit             qs[$];

  logic           prev_stall = 1'b0;
  logic [2*W-1:0] held_p;
  logic [3:0]     held_m;
  logic [2*W-1:0] last_p;
  logic [3:0]     last_m;

  always #(CLK_P/2) clk = ~clk;

  booth_part_mul #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_prod(out_prod), .out_swap(out_swap)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int activity(input logic [H:0] v);
    int c = 0;
    logic p = 1'b0;
    for (int i = 0; i <= H; i++) begin
      if (v[i] != p) c++;
      p = v[i];
    end
    return c;
  endfunction

  function automatic logic [3:0] exp_mask(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [3:0] m;
    for (int k = 0; k < 4; k++) begin
      logic [H:0] xa, xb;
      xa = k[0] ? {a[W-1], a[W-1:H]} : {1'b0, a[H-1:0]};
      xb = k[1] ? {b[W-1], b[W-1:H]} : {1'b0, b[H-1:0]};
      m[k] = activity(xa) < activity(xb);
    end
    return m;
  endfunction

  // reference model and port monitor, mid-cycle
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_stall) begin
        check(out_valid && out_prod == held_p && out_swap == held_m, "R3 hold",
              {out_prod, 28'h0, out_swap}, {held_p, 28'h0, held_m});
      end
      if (out_valid && out_ready) begin
        if (qp.size() == 0) begin
          check(1'b0, "R3 unexpected output", 64'(out_prod), 64'h0);
        end else begin
          logic [2*W-1:0] ep;
          logic [3:0] em;
          int t;
          bit s;
          ep = qp.pop_front(); em = qm.pop_front();
          t = qt.pop_front();  s = qs.pop_front();
          check(out_prod == ep, "R1 product", 64'(out_prod), 64'(ep));
          check(out_swap == em, "R4 swap mask", 64'(out_swap), 64'(em));
          if (!s && !stall_mode)
            check(cyc - t == 2, "R2 latency", 64'(cyc - t), 64'd2);
          last_p = out_prod;
          last_m = out_swap;
        end
      end
      prev_stall = out_valid && !out_ready;
      held_p = out_prod;
      held_m = out_swap;
      if (!in_ready)
        check(out_valid && !out_ready, "R3 ready low only when full", 64'(out_ready), 64'h0);
      if (in_valid && in_ready) begin
        qp.push_back({{W{in_a[W-1]}}, in_a} * {{W{in_b[W-1]}}, in_b});
        qm.push_back(exp_mask(in_a, in_b));
        qt.push_back(cyc);
        qs.push_back(stall_mode);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = stall_mode ? 1'($urandom_range(1, 0)) : 1'b1;
  end

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b);
    in_a = a; in_b = b; in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (qp.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R6 out_valid after reset", 64'(out_valid), 64'h0);
    check(in_ready, "R6 in_ready after reset", 64'(in_ready), 64'h1);

    send(16'h8000, 16'h8000); drain();
    check(last_p == 32'h4000_0000, "R1 most negative squared", 64'(last_p), 64'h4000_0000);
    send(16'h8000, 16'h7FFF); drain();
    check(last_p == 32'hC000_8000, "R1 most negative by max", 64'(last_p), 64'hC000_8000);
    send(16'h0000, 16'h8000); drain();
    check(last_p == '0, "R7 zero a", 64'(last_p), 64'h0);
    send(16'h1234, 16'h0000); drain();
    check(last_p == '0, "R7 zero b", 64'(last_p), 64'h0);
    send(16'h0055, 16'h5500); drain();
    check(last_m == 4'b1000, "R5 single quarter swap", 64'(last_m), 64'h8);
    send(16'hFFFF, 16'hFFFF); drain();
    check(last_p == 32'h1, "R1 minus one squared", 64'(last_p), 64'h1);
    send(16'hAAAA, 16'h0000); drain();
    check(last_m == 4'b0000, "R4 tie or quieter b no swap", 64'(last_m), 64'h0);

    for (int i = 0; i < 300; i++) send(W'($urandom), W'($urandom));
    drain();

    stall_mode = 1'b1;
    for (int i = 0; i < 400; i++) send(W'($urandom), W'($urandom));
    stall_mode = 1'b0;
    drain();

    done = 1'b1;
    summary();
  end
endmodule